// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block serializes bytes onto a single asynchronous line. In front of the shift engine sits one holding stage. The host can therefore queue the next byte while the current frame is still going out, and consecutive frames leave with only one clock of idle line between them. A small register port lets the host write data, set the configuration, read the status, and clear the sticky flags. Two level interrupt requests are produced, one for "holding stage free" and one for "everything sent". The second is also cleared by an acknowledge strobe from the interrupt controller.

Each frame consists of a low start bit, eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. Every bit lasts 16 pulses of the external `baud_tick` input. The bit rate therefore comes entirely from outside the block. When software clears the enable bit, the shutdown waits until the frame in flight and any queued byte have been sent. Only after that does the pin-drive enable drop, so that a shared or half-duplex line can be handed back.

Top module: `sertx_top`

Register map (`addr`): 0 = data (write only, reads 0). 1 = status: bit0 `empty`, bit1 `done`, bit2 `ovr`. Writing 1 to bit1 or bit2 clears that flag. 2 = control (read/write): bit0 `en`, bit1 `par_en`, bit2 `par_odd`, bit3 `two_stop`, bit4 `ie_empty`, bit5 `ie_done`. 3 reads 0.

## Requirements
- R1: After reset, `txd` is 1, `txd_oe` is 0, status reads 0x01, and both interrupt outputs are 0.
- R2: A frame is a start bit of 0, then the 8 data bits LSB first, then the optional parity bit, then the stop bits of 1. Each bit lasts 16 `baud_tick` pulses. The line is 1 whenever no frame is in progress.
- R3: With `par_en`=1, a parity bit follows the last data bit. It equals the XOR of the data bits when `par_odd`=0 (even parity) and its inverse when `par_odd`=1.
- R4: `two_stop` selects two stop bits (1) or one (0). A frame therefore spans (10 + `par_en` + `two_stop`) bit times.
- R5: The queued byte moves into the shift engine as soon as the engine is idle, and status bit0 (`empty`) is 1 again from then on. If a byte is waiting when a frame ends, its start bit begins one clock after the last stop bit ends.
- R6: `irq_empty` = `empty` AND `ie_empty` AND `gie`. It stays asserted for as long as the holding stage is free.
- R7: A data write while the holding stage is full is discarded and sets the sticky status bit2 (`ovr`). Writing 1 to status bit2 clears it.
- R8: Status bit1 (`done`) becomes 1 only after the last stop bit of a frame ends while no byte is queued. Writing 1 to status bit1 clears it.
- R9: `irq_done` = `done` AND `ie_done` AND `gie`. A one-clock pulse on `irq_ack` clears `done`.
- R10: After `en` is cleared, the frame in flight and a queued byte are still sent in full. `txd_oe` stays 1 until both are gone, then drops to 0. While `txd_oe` is 0, `txd` is 1.
- R11: A data write while `en` is 0 has no effect: nothing is queued or sent, and `ovr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | Oversampling pulse, 16 per bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational from `addr`) |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge of the transmit-complete interrupt |
| irq_empty | output | 1 | Holding-stage-free interrupt request |
| irq_done | output | 1 | Transmit-complete interrupt request |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Pin-drive enable for `txd` |

## Verification
The embedded properties take for granted that `addr` and `wdata` are meaningful whenever `wr_en` is high. They also take for granted that `irq_ack` is a short strobe and that nothing but `baud_tick` paces the shift engine. The bench changes register inputs only at falling clock edges. It holds `wr_en` for exactly one cycle per access. It runs `baud_tick` either continuously or on a fixed divide, and never changes the divide while a frame is on the line. Stimulus never depends on the internal timing of the shift engine; it observes only `txd`, `txd_oe`, `rdata` and the interrupt pins.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } sertx_reg_e;

  // Control word, LSB first: en, par_en, par_odd, two_stop, ie_empty, ie_done
  typedef struct packed {
    logic ie_done;
    logic ie_empty;
    logic two_stop;
    logic par_odd;
    logic par_en;
    logic en;
  } sertx_cfg_t;

  localparam int CFG_W = $bits(sertx_cfg_t);

  localparam int STAT_EMPTY = 0;
  localparam int STAT_DONE  = 1;
  localparam int STAT_OVR   = 2;

endpackage

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              busy,
  output logic              txd_bit,
  output logic              frame_done
);

  localparam int CNT_W    = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int SR_W     = DATA_W + 3;
  localparam int MAX_BITS = DATA_W + 4;
  localparam int LEN_W    = $clog2(MAX_BITS + 1);

  logic             busy_q, busy_d;
  logic [SR_W-1:0]  sr_q, sr_d;
  logic [CNT_W-1:0] tick_q, tick_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             par_bit;

  assign par_bit = (^load_data) ^ par_odd;

  always_comb begin
    busy_d     = busy_q;
    sr_d       = sr_q;
    tick_d     = tick_q;
    left_d     = left_q;
    frame_done = 1'b0;
    if (load) begin
      busy_d = 1'b1;
      // stop, parity-or-stop, data, start; ones shift in from the top
      sr_d   = {1'b1, (par_en ? par_bit : 1'b1), load_data, 1'b0};
      tick_d = '0;
      left_d = LEN_W'(DATA_W + 2) + LEN_W'(par_en) + LEN_W'(two_stop);
    end else if (busy_q && baud_tick) begin
      if (tick_q == CNT_W'(OSR - 1)) begin
        tick_d = '0;
        sr_d   = {1'b1, sr_q[SR_W-1:1]};
        left_d = left_q - LEN_W'(1);
        if (left_q == LEN_W'(1)) begin
          busy_d     = 1'b0;
          frame_done = 1'b1;
        end
      end else begin
        tick_d = tick_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sr_q   <= '1;
      tick_q <= '0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      sr_q   <= sr_d;
      tick_q <= tick_d;
      left_q <= left_d;
    end
  end

  assign busy    = busy_q;
  assign txd_bit = busy_q ? sr_q[0] : 1'b1;

  // R5: the control side only hands over a byte when the engine is idle
  p_load_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);

  // R4: remaining bit count of a running frame stays within the longest frame
  p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0) && (left_q <= LEN_W'(MAX_BITS)));

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              gie,
  input  logic              irq_ack,
  input  logic              busy,
  input  logic              frame_done,
  output sertx_cfg_t        cfg,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              full,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_empty,
  output logic              irq_done
);

  sertx_cfg_t        cfg_q, cfg_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic              done_q, done_d;
  logic              ovr_q, ovr_d;
  logic              wr_data, wr_stat, wr_ctl, accept;

  assign wr_data = wr_en && (addr == REG_DATA);
  assign wr_stat = wr_en && (addr == REG_STAT);
  assign wr_ctl  = wr_en && (addr == REG_CTRL);
  assign load    = full_q && !busy;
  assign accept  = wr_data && cfg_q.en && !full_q;

  always_comb begin
    cfg_d  = cfg_q;
    hold_d = hold_q;
    full_d = full_q;
    if (wr_ctl) cfg_d = sertx_cfg_t'(wdata[CFG_W-1:0]);
    if (accept) begin
      hold_d = wdata;
      full_d = 1'b1;
    end else if (load) begin
      full_d = 1'b0;
    end
    ovr_d  = (ovr_q && !(wr_stat && wdata[STAT_OVR]))
           || (wr_data && cfg_q.en && full_q);
    done_d = (frame_done && !full_q)
           || (done_q && !((wr_stat && wdata[STAT_DONE]) || irq_ack));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      hold_q <= '0;
      full_q <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      if (accept) hold_q <= hold_d;
      full_q <= full_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    case (addr)
      REG_STAT: rdata = DATA_W'({ovr_q, done_q, !full_q});
      REG_CTRL: rdata = DATA_W'(cfg_q);
      default:  rdata = '0;
    endcase
  end

  assign cfg       = cfg_q;
  assign load_data = hold_q;
  assign full      = full_q;
  assign irq_empty = !full_q && cfg_q.ie_empty && gie;
  assign irq_done  = done_q && cfg_q.ie_done && gie;

  // R8: completion can only appear once the engine has stopped
  p_done_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy);

  // R7: the overwrite flag holds until software clears it
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(wr_stat && wdata[STAT_OVR])) |=> ovr_q);

  // R11: with the enable bit clear, the holding stage can never fill
  p_no_fill_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.en && !full_q) |=> !full_q);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              gie,
  input  logic              irq_ack,
  output logic              irq_empty,
  output logic              irq_done,
  output logic              txd,
  output logic              txd_oe
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  sertx_cfg_t        cfg;
  logic              load, full, busy, txd_bit, frame_done;
  logic [DATA_W-1:0] load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sertx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .gie        (gie),
    .irq_ack    (irq_ack),
    .busy       (busy),
    .frame_done (frame_done),
    .cfg        (cfg),
    .load       (load),
    .load_data  (load_data),
    .full       (full),
    .rdata      (rdata),
    .irq_empty  (irq_empty),
    .irq_done   (irq_done)
  );

  sertx_shift #(.DATA_W(DATA_W), .OSR(OSR)) shift_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .baud_tick  (baud_tick),
    .load       (load),
    .load_data  (load_data),
    .par_en     (cfg.par_en),
    .par_odd    (cfg.par_odd),
    .two_stop   (cfg.two_stop),
    .busy       (busy),
    .txd_bit    (txd_bit),
    .frame_done (frame_done)
  );

  // drive stays on while enabled or while anything is left to send
  assign txd_oe = cfg.en || full || busy;
  assign txd    = txd_bit;

  // R10: once the pin is released the line sits at its idle level
  p_quiet_when_released_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !txd_oe |-> txd);

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

  logic       clk, rst_n, baud_tick, wr_en, gie, irq_ack;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq_empty, irq_done, txd, txd_oe;

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  int     tdiv = 1;
  int     tphase = 0;
  bit     got_a;

  sertx_top dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .gie(gie), .irq_ack(irq_ack),
    .irq_empty(irq_empty), .irq_done(irq_done), .txd(txd), .txd_oe(txd_oe)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tphase >= tdiv - 1) begin
      tphase    <= 0;
      baud_tick <= 1'b1;
    end else begin
      tphase    <= tphase + 1;
      baud_tick <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [11:0] exp_frame(logic [7:0] d, bit p, bit o);
    return {2'b11, (p ? ((^d) ^ o) : 1'b1), d, 1'b0};
  endfunction

  task automatic cap(input int nb, output logic [11:0] bits, output longint t0, output bit ok);
    int w;
    w = 0; ok = 1'b1; bits = '1; t0 = 0;
    @(negedge clk);
    while (txd !== 1'b0) begin
      @(negedge clk);
      w++;
      if (w > 3000) begin ok = 1'b0; return; end
    end
    t0 = cyc;
    repeat (8 * tdiv) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      bits[i] = txd;
      if (i < nb - 1) repeat (16 * tdiv) @(negedge clk);
    end
  endtask

  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  s;
    logic [11:0] fa, fb;
    longint      ta, tb;
    bit          oka, okb;
    int          lows;
    logic [7:0]  pats [6];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80, 8'h3C};

    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00; gie = 1'b0; irq_ack = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(txd_oe === 1'b0, "R1 txd_oe", txd_oe, 0);
    rd(2'd1, s);
    chk(s === 8'h01, "R1 status", s, 8'h01);
    chk(irq_empty === 1'b0 && irq_done === 1'b0, "R1 irqs", {irq_empty, irq_done}, 0);

    // R11 data write while disabled
    wr(2'd0, 8'h55);
    count_low(300, lows);
    chk(lows == 0 && txd_oe === 1'b0, "R11 line quiet", lows, 0);
    rd(2'd1, s);
    chk(s === 8'h01, "R11 status unchanged", s, 8'h01);

    // R2 R3 R4 R5 R8 sweep over all formats and several patterns
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 6; k++) begin
        bit p, o, t;
        int nb;
        logic [7:0] a, b;
        p = c[0]; o = c[1]; t = c[2];
        nb = 10 + int'(p) + int'(t);
        a = pats[k];
        b = pats[k] ^ 8'h5A ^ 8'(c);
        wr(2'd2, {2'b00, t, o, p, 1'b1});
        fork
          begin
            cap(nb, fa, ta, oka);
            cap(nb, fb, tb, okb);
          end
          begin
            logic [7:0] s2;
            wr(2'd0, a);
            wr(2'd0, b);
            rd(2'd1, s2);
            chk(s2[0] === 1'b0, "R5 second byte queued", s2, 0);
          end
        join
        chk(oka && fa === exp_frame(a, p, o), "R2 R3 first frame", fa, exp_frame(a, p, o));
        chk(okb && fb === exp_frame(b, p, o), "R2 R3 second frame", fb, exp_frame(b, p, o));
        chk(tb - ta == longint'(nb * 16 + 1), "R4 R5 frame spacing", tb - ta, nb * 16 + 1);
        repeat (16) @(negedge clk);
        rd(2'd1, s);
        chk(s === 8'h03, "R8 done after last frame", s, 8'h03);
        wr(2'd1, 8'h02);
        rd(2'd1, s);
        chk(s === 8'h01, "R8 done cleared by write", s, 8'h01);
      end
    end

    // R2 sparse tick: each bit spans 16 ticks, ticks every third clock
    tdiv = 3;
    repeat (6) @(negedge clk);
    wr(2'd2, 8'h0F);
    fork
      cap(12, fa, ta, oka);
      wr(2'd0, 8'h96);
    join
    chk(oka && fa === exp_frame(8'h96, 1, 1), "R2 R3 sparse tick frame", fa, exp_frame(8'h96, 1, 1));
    repeat (80) @(negedge clk);
    wr(2'd1, 8'h02);
    tdiv = 1;
    repeat (6) @(negedge clk);

    // R6 empty interrupt gating
    wr(2'd2, 8'h11);
    #1 chk(irq_empty === 1'b0, "R6 masked by gie", irq_empty, 0);
    @(negedge clk); gie = 1'b1;
    #1 chk(irq_empty === 1'b1, "R6 asserted when free", irq_empty, 1);

    // R7 overwrite, R8 done not set while a byte waits
    got_a = 1'b0;
    fork
      begin
        cap(10, fa, ta, oka);
        got_a = 1'b1;
        cap(10, fb, tb, okb);
      end
      begin
        logic [7:0] s3;
        wr(2'd0, 8'h5C);
        wr(2'd0, 8'hC3);
        #1 chk(irq_empty === 1'b0, "R6 deasserted when full", irq_empty, 0);
        wr(2'd0, 8'h77);
        rd(2'd1, s3);
        chk(s3 === 8'h04, "R7 overwrite flagged", s3, 8'h04);
        wait (got_a);
        repeat (12) @(negedge clk);
        rd(2'd1, s3);
        chk(s3 === 8'h05, "R8 no done between frames", s3, 8'h05);
      end
    join
    chk(oka && fa === exp_frame(8'h5C, 0, 0), "R7 first frame", fa, exp_frame(8'h5C, 0, 0));
    chk(okb && fb === exp_frame(8'hC3, 0, 0), "R7 queued byte kept", fb, exp_frame(8'hC3, 0, 0));
    count_low(300, lows);
    chk(lows == 0, "R7 discarded byte never sent", lows, 0);
    rd(2'd1, s);
    chk(s === 8'h07, "R8 done with ovr", s, 8'h07);

    // R9 done interrupt and acknowledge
    wr(2'd2, 8'h31);
    #1 chk(irq_done === 1'b1, "R9 irq_done asserted", irq_done, 1);
    @(negedge clk); gie = 1'b0;
    #1 chk(irq_done === 1'b0, "R9 masked by gie", irq_done, 0);
    @(negedge clk); gie = 1'b1; irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    #1 chk(irq_done === 1'b0, "R9 cleared by ack", irq_done, 0);
    rd(2'd1, s);
    chk(s === 8'h05, "R9 done bit clear after ack", s, 8'h05);
    wr(2'd1, 8'h04);
    rd(2'd1, s);
    chk(s === 8'h01, "R7 ovr cleared by write", s, 8'h01);

    // R10 deferred disable, R11 write after disable
    wr(2'd2, 8'h01);
    fork
      begin
        cap(10, fa, ta, oka);
        cap(10, fb, tb, okb);
      end
      begin
        wr(2'd0, 8'hE1);
        wr(2'd0, 8'h2B);
        wr(2'd2, 8'h00);
        #1 chk(txd_oe === 1'b1, "R10 drive held while pending", txd_oe, 1);
        wr(2'd0, 8'h11);
      end
    join
    chk(oka && fa === exp_frame(8'hE1, 0, 0), "R10 frame in flight sent", fa, exp_frame(8'hE1, 0, 0));
    chk(okb && fb === exp_frame(8'h2B, 0, 0), "R10 queued frame sent", fb, exp_frame(8'h2B, 0, 0));
    repeat (16) @(negedge clk);
    chk(txd_oe === 1'b0 && txd === 1'b1, "R10 pin released", {txd_oe, txd}, 2'b01);
    rd(2'd1, s);
    chk(s === 8'h03, "R11 no overwrite while disabled", s, 8'h03);
    count_low(300, lows);
    chk(lows == 0, "R11 nothing sent after disable", lows, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule